// File: doc/BRIEF.md
# Front-End Stack Pointer Tracker

This block sits beside the instruction decoder and absorbs the implicit stack pointer adjustments of push, pop, call and return. It uses its own small adder, so the execution units never see a separate pointer-update micro-op for these instructions. The tracker keeps two pieces of state. The first is a base, which is the stack pointer as the back end last knew it. The second is a signed offset that collects all stack adjustments made since that base was taken. Each accepted stack operation gets the pointer value it must use for its memory access.

When a non-stack instruction needs the real pointer, the decoder raises a touch request. The tracker then emits a sync request that carries the pending offset, folds that offset into its base, and clears the offset. The tracker also emits a sync on its own when the next stack operation would carry the offset outside its signed range; in that case it holds that operation back for one cycle. A non-stack instruction that writes the pointer reloads the base directly. A commit input snapshots the tracker state, and a flush input restores that snapshot after a misprediction.

Top module: `spt_tracker`

## Requirements
- R1: After reset the base equals the parameter RESET_SP and the offset is zero. res_valid and sync_req are low during reset. The first pop after reset reports RESET_SP.
- R2: op_kind encodes 2'b00 push, 2'b01 pop, 2'b10 call and 2'b11 return. The operand size is 4 bytes when op_wide is 1 and 2 bytes when it is 0. An accepted push or call reports base+offset-size and lowers the offset by the size.
- R3: An accepted pop or return reports base+offset as it stood before the operation, then raises the offset by the size. A push followed at once by a pop of the same size reports the same pointer twice.
- R4: A stack operation is accepted in a cycle where op_valid and op_ready are both high. Its res_valid pulse and res_sp value appear on the next cycle, and there is exactly one pulse per accepted operation.
- R5: A touch (sp_touch) raises sync_req on the next cycle, with sync_delta equal to the offset. The offset is then folded into the base and cleared, so a touch made at once after another reports sync_delta 0.
- R6: The offset is a signed 8-bit value (-128..127). If a stack operation would move it outside that range, op_ready is low, a sync with the current offset is issued, and the operation is accepted on the next cycle.
- R7: A pointer write (sp_write) loads sp_write_val as the new base and clears the offset. It raises no sync_req.
- R8: commit_mark saves the current base and offset. flush restores the saved pair, and it has priority over every other input.
- R9: Priority from highest to lowest is flush, sp_write, sp_touch, then the stack operation. op_ready is low whenever any of the first three is high.
- R10: Stack operations whose offset stays in range never raise sync_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A decoded stack operation is offered |
| op_kind | input | 2 | 00 push, 01 pop, 10 call, 11 return |
| op_wide | input | 1 | 1: 4-byte operand, 0: 2-byte operand |
| op_ready | output | 1 | The offered operation is accepted this cycle |
| sp_touch | input | 1 | A non-stack instruction reads the pointer; fold the offset |
| sp_write | input | 1 | A non-stack instruction writes the pointer |
| sp_write_val | input | ADDR_W | New pointer value for sp_write |
| commit_mark | input | 1 | Save the current state as the recovery point |
| flush | input | 1 | Restore the saved recovery point |
| res_valid | output | 1 | res_sp holds the pointer for an accepted operation |
| res_sp | output | ADDR_W | Pointer value used by the stack operation |
| sync_req | output | 1 | Pointer-sync micro-op request |
| sync_delta | output | DELTA_W | Offset to be added to the architectural pointer |

## Verification
Several stimulus streams exercise the main function. Runs of 4-byte pushes show that the offset decreases and that each result is taken after the adjustment. Runs of 2-byte pops show that each result is taken before the adjustment. Alternating call and return pairs of mixed sizes show that the direction comes from the kind and the size from op_wide. Long same-direction bursts in each direction drive the offset to its exact limits, which shows where the forced sync and the one-cycle hold fall. Touches, writes and flushes, some offered in the same cycle as a stack operation, separate the folding path from the reload path, and separate the restore path from both.

// File: rtl/spt_pkg.sv
package spt_pkg;

    typedef enum logic [1:0] {
        SK_PUSH = 2'b00,
        SK_POP  = 2'b01,
        SK_CALL = 2'b10,
        SK_RET  = 2'b11
    } stk_kind_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_FLUSH,
        ACT_LOAD,
        ACT_FOLD_TOUCH,
        ACT_FOLD_OVF,
        ACT_ACCEPT
    } spt_act_e;

    localparam int unsigned BYTES_WIDE   = 4;
    localparam int unsigned BYTES_NARROW = 2;
    localparam int unsigned SIZE_W       = 4;

    // Push and call move the pointer down; pop and return move it up.
    function automatic logic kind_moves_down(input stk_kind_e k);
        return (k == SK_PUSH) || (k == SK_CALL);
    endfunction

    function automatic logic [SIZE_W-1:0] op_bytes(input logic wide);
        return wide ? SIZE_W'(BYTES_WIDE) : SIZE_W'(BYTES_NARROW);
    endfunction

endpackage

// File: rtl/spt_delta_adder.sv
module spt_delta_adder
    import spt_pkg::*;
#(
    parameter int DELTA_W = 8
) (
    input  logic [DELTA_W-1:0] delta_cur,
    input  stk_kind_e          kind,
    input  logic               wide,
    output logic [DELTA_W-1:0] delta_next,
    output logic               out_of_range
);
    localparam int EXT_W = DELTA_W + 1;

    logic [EXT_W-1:0]  ext_cur;
    logic [EXT_W-1:0]  ext_size;
    logic [EXT_W-1:0]  ext_sum;

    always_comb begin
        ext_cur  = {delta_cur[DELTA_W-1], delta_cur};
        ext_size = EXT_W'(op_bytes(wide));
        if (kind_moves_down(kind)) begin
            ext_sum = ext_cur - ext_size;
        end else begin
            ext_sum = ext_cur + ext_size;
        end
        out_of_range = ext_sum[EXT_W-1] != ext_sum[EXT_W-2];
        delta_next   = ext_sum[DELTA_W-1:0];
    end
endmodule

// File: rtl/spt_addr_gen.sv
module spt_addr_gen
    import spt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DELTA_W = 8
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [DELTA_W-1:0] delta,
    input  stk_kind_e          kind,
    input  logic               wide,
    output logic [ADDR_W-1:0]  cur_sp,
    output logic [ADDR_W-1:0]  op_sp
);
    localparam int PAD_W = ADDR_W - DELTA_W;

    logic [ADDR_W-1:0] delta_sx;

    always_comb begin
        delta_sx = {{PAD_W{delta[DELTA_W-1]}}, delta};
        cur_sp   = base + delta_sx;
        if (kind_moves_down(kind)) begin
            op_sp = cur_sp - ADDR_W'(op_bytes(wide));
        end else begin
            op_sp = cur_sp;
        end
    end
endmodule

// File: rtl/spt_arbiter.sv
module spt_arbiter
    import spt_pkg::*;
(
    input  logic     flush,
    input  logic     sp_write,
    input  logic     sp_touch,
    input  logic     op_valid,
    input  logic     op_out_of_range,
    output spt_act_e act,
    output logic     op_ready
);
    always_comb begin
        if (flush) begin
            act = ACT_FLUSH;
        end else if (sp_write) begin
            act = ACT_LOAD;
        end else if (sp_touch) begin
            act = ACT_FOLD_TOUCH;
        end else if (op_valid && op_out_of_range) begin
            act = ACT_FOLD_OVF;
        end else if (op_valid) begin
            act = ACT_ACCEPT;
        end else begin
            act = ACT_IDLE;
        end
        op_ready = !flush && !sp_write && !sp_touch && !op_out_of_range;
    end
endmodule

// File: rtl/spt_ckpt.sv
module spt_ckpt #(
    parameter int                ADDR_W   = 32,
    parameter int                DELTA_W  = 8,
    parameter logic [ADDR_W-1:0] RESET_SP = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               save,
    input  logic [ADDR_W-1:0]  base_in,
    input  logic [DELTA_W-1:0] delta_in,
    output logic [ADDR_W-1:0]  base_saved,
    output logic [DELTA_W-1:0] delta_saved
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_saved  <= RESET_SP;
            delta_saved <= '0;
        end else if (save) begin
            base_saved  <= base_in;
            delta_saved <= delta_in;
        end
    end
endmodule

// File: rtl/spt_tracker.sv
module spt_tracker
    import spt_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                DELTA_W  = 8,
    parameter logic [ADDR_W-1:0] RESET_SP = 32'h0000_8000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [1:0]         op_kind,
    input  logic               op_wide,
    output logic               op_ready,
    input  logic               sp_touch,
    input  logic               sp_write,
    input  logic [ADDR_W-1:0]  sp_write_val,
    input  logic               commit_mark,
    input  logic               flush,
    output logic               res_valid,
    output logic [ADDR_W-1:0]  res_sp,
    output logic               sync_req,
    output logic [DELTA_W-1:0] sync_delta
);
    stk_kind_e          kind;
    logic [ADDR_W-1:0]  base_q;
    logic [DELTA_W-1:0] delta_q;
    logic [DELTA_W-1:0] delta_step;
    logic               step_oor;
    logic               op_oor;
    logic [ADDR_W-1:0]  cur_sp;
    logic [ADDR_W-1:0]  op_sp;
    logic [ADDR_W-1:0]  ck_base;
    logic [DELTA_W-1:0] ck_delta;
    spt_act_e           act;
    logic               ck_save;

    assign kind    = stk_kind_e'(op_kind);
    assign op_oor  = op_valid && step_oor;
    assign ck_save = commit_mark && (act != ACT_FLUSH);

    spt_delta_adder #(.DELTA_W(DELTA_W)) u_adder (
        .delta_cur    (delta_q),
        .kind         (kind),
        .wide         (op_wide),
        .delta_next   (delta_step),
        .out_of_range (step_oor)
    );

    spt_addr_gen #(.ADDR_W(ADDR_W), .DELTA_W(DELTA_W)) u_agen (
        .base   (base_q),
        .delta  (delta_q),
        .kind   (kind),
        .wide   (op_wide),
        .cur_sp (cur_sp),
        .op_sp  (op_sp)
    );

    spt_arbiter u_arb (
        .flush           (flush),
        .sp_write        (sp_write),
        .sp_touch        (sp_touch),
        .op_valid        (op_valid),
        .op_out_of_range (op_oor),
        .act             (act),
        .op_ready        (op_ready)
    );

    spt_ckpt #(.ADDR_W(ADDR_W), .DELTA_W(DELTA_W), .RESET_SP(RESET_SP)) u_ckpt (
        .clk         (clk),
        .rst         (rst),
        .save        (ck_save),
        .base_in     (base_q),
        .delta_in    (delta_q),
        .base_saved  (ck_base),
        .delta_saved (ck_delta)
    );

    // Base and offset state
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= RESET_SP;
            delta_q <= '0;
        end else begin
            unique case (act)
                ACT_FLUSH: begin
                    base_q  <= ck_base;
                    delta_q <= ck_delta;
                end
                ACT_LOAD: begin
                    base_q  <= sp_write_val;
                    delta_q <= '0;
                end
                ACT_FOLD_TOUCH, ACT_FOLD_OVF: begin
                    base_q  <= cur_sp;
                    delta_q <= '0;
                end
                ACT_ACCEPT: begin
                    delta_q <= delta_step;
                end
                default: ;
            endcase
        end
    end

    // Registered result and sync outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_sp     <= '0;
            sync_req   <= 1'b0;
            sync_delta <= '0;
        end else begin
            res_valid <= (act == ACT_ACCEPT);
            sync_req  <= (act == ACT_FOLD_TOUCH) || (act == ACT_FOLD_OVF);
            if (act == ACT_ACCEPT) begin
                res_sp <= op_sp;
            end
            if ((act == ACT_FOLD_TOUCH) || (act == ACT_FOLD_OVF)) begin
                sync_delta <= delta_q;
            end
        end
    end
endmodule

// File: rtl/spt_tracker_chk.sv
module spt_tracker_chk #(
    parameter int ADDR_W  = 32,
    parameter int DELTA_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               op_valid,
    input logic [1:0]         op_kind,
    input logic               op_wide,
    input logic               op_ready,
    input logic               sp_touch,
    input logic               sp_write,
    input logic               flush,
    input logic               res_valid,
    input logic [ADDR_W-1:0]  res_sp,
    input logic               sync_req,
    input logic [DELTA_W-1:0] sync_delta
);
    logic acc;
    logic acc_down;
    logic acc_up;
    logic touch_wins;
    logic ovf_stall;

    assign acc        = op_valid && op_ready;
    assign acc_down   = acc && !op_kind[0];
    assign acc_up     = acc && op_kind[0];
    assign touch_wins = sp_touch && !flush && !sp_write;
    assign ovf_stall  = op_valid && !op_ready && !flush && !sp_write && !sp_touch;

    assert_res_follows_accept_R4: assert property (@(posedge clk) disable iff (rst)
        acc |=> res_valid);

    assert_no_res_without_accept_R4: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !res_valid);

    assert_push_pop_match_R3: assert property (@(posedge clk) disable iff (rst)
        acc_down ##1 (acc_up && op_wide == $past(op_wide)) |=> res_sp == $past(res_sp));

    assert_touch_syncs_R5: assert property (@(posedge clk) disable iff (rst)
        touch_wins |=> sync_req);

    assert_double_touch_zero_R5: assert property (@(posedge clk) disable iff (rst)
        touch_wins ##1 touch_wins |=> sync_delta == '0);

    assert_ovf_stall_syncs_R6: assert property (@(posedge clk) disable iff (rst)
        ovf_stall |=> sync_req);

    assert_write_no_sync_R7: assert property (@(posedge clk) disable iff (rst)
        (sp_write && !flush) |=> !sync_req);

    assert_priority_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        (flush || sp_write || sp_touch) |-> !op_ready);

    assert_exclusive_outputs_R10: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && sync_req));
endmodule

bind spt_tracker spt_tracker_chk #(.ADDR_W(ADDR_W), .DELTA_W(DELTA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .op_wide    (op_wide),
    .op_ready   (op_ready),
    .sp_touch   (sp_touch),
    .sp_write   (sp_write),
    .flush      (flush),
    .res_valid  (res_valid),
    .res_sp     (res_sp),
    .sync_req   (sync_req),
    .sync_delta (sync_delta)
);

// File: tb/spt_tracker_test.sv
module spt_tracker_test;
    localparam logic [31:0] RST_SP = 32'h0000_8000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic        op_wide = 1'b0;
    logic        op_ready;
    logic        sp_touch = 1'b0;
    logic        sp_write = 1'b0;
    logic [31:0] sp_write_val = '0;
    logic        commit_mark = 1'b0;
    logic        flush = 1'b0;
    logic        res_valid;
    logic [31:0] res_sp;
    logic        sync_req;
    logic [7:0]  sync_delta;

    always #10 clk = ~clk;

    spt_tracker uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_wide(op_wide), .op_ready(op_ready), .sp_touch(sp_touch),
        .sp_write(sp_write), .sp_write_val(sp_write_val),
        .commit_mark(commit_mark), .flush(flush), .res_valid(res_valid),
        .res_sp(res_sp), .sync_req(sync_req), .sync_delta(sync_delta)
    );

    typedef struct {
        logic        is_sync;
        logic [31:0] value;
        string       req;
    } exp_t;

    exp_t        expq[$];
    int          n_checks = 0;
    int          n_fail   = 0;
    logic [31:0] m_base   = RST_SP;
    int          m_delta  = 0;
    logic [31:0] ck_base  = RST_SP;
    int          ck_delta = 0;
    bit          done     = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        op_valid = 0; sp_touch = 0; sp_write = 0; commit_mark = 0; flush = 0;
    endtask

    task automatic step();
        @(posedge clk); #2;
        clear_inputs();
    endtask

    task automatic push_sync(input string req);
        exp_t e;
        e.is_sync = 1; e.value = 32'(m_delta & 8'hFF); e.req = req;
        expq.push_back(e);
        m_base  = m_base + 32'(m_delta);
        m_delta = 0;
    endtask

    // Offer one stack op; retries while the design holds it back.
    task automatic do_op(input logic [1:0] k, input logic w, input string req, input bit expect_stall);
        int sz;
        int nd;
        bit accepted;
        bit stalled;
        exp_t e;
        sz = w ? 4 : 2;
        accepted = 0;
        stalled = 0;
        while (!accepted) begin
            step();
            op_valid = 1; op_kind = k; op_wide = w;
            nd = (k[0] == 1'b0) ? m_delta - sz : m_delta + sz;
            #1;
            if (nd < -128 || nd > 127) begin
                check(op_ready == 1'b0, "R6 ready low on range exit", 32'(op_ready), 0);
                push_sync("R6 forced sync");
                stalled = 1;
            end else begin
                check(op_ready == 1'b1, "R4 ready", 32'(op_ready), 1);
                e.is_sync = 0; e.req = req;
                e.value = (k[0] == 1'b0) ? m_base + 32'(m_delta) - 32'(sz) : m_base + 32'(m_delta);
                expq.push_back(e);
                m_delta = nd;
                accepted = 1;
            end
        end
        if (expect_stall != stalled) begin
            check(0, "R6 stall position", 32'(stalled), 32'(expect_stall));
        end
    endtask

    task automatic do_touch(input bit with_op);
        step();
        sp_touch = 1;
        if (with_op) begin
            op_valid = 1; op_kind = 2'b01; op_wide = 1;
        end
        #1;
        if (with_op) check(op_ready == 1'b0, "R9 touch blocks op", 32'(op_ready), 0);
        push_sync("R5 touch sync");
    endtask

    task automatic do_write(input logic [31:0] v, input bit with_op);
        step();
        sp_write = 1; sp_write_val = v;
        if (with_op) begin
            op_valid = 1; op_kind = 2'b00; op_wide = 1; sp_touch = 1;
        end
        #1;
        if (with_op) check(op_ready == 1'b0, "R9 write blocks op", 32'(op_ready), 0);
        m_base = v; m_delta = 0;
    endtask

    task automatic do_commit();
        step();
        commit_mark = 1;
        ck_base = m_base; ck_delta = m_delta;
    endtask

    task automatic do_flush(input bit with_others);
        step();
        flush = 1;
        if (with_others) begin
            sp_write = 1; sp_write_val = 32'hDEAD_0000; sp_touch = 1;
            op_valid = 1; op_kind = 2'b00; op_wide = 1; commit_mark = 1;
        end
        #1;
        check(op_ready == 1'b0, "R9 flush blocks op", 32'(op_ready), 0);
        m_base = ck_base; m_delta = ck_delta;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Monitor: compares design outputs with the expected queue.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst && (res_valid || sync_req)) begin
                if (expq.size() == 0) begin
                    check(0, "R10 unexpected output", {30'd0, sync_req, res_valid}, 0);
                end else begin
                    e = expq.pop_front();
                    if (e.is_sync) begin
                        check(sync_req && !res_valid, e.req, {31'd0, sync_req}, 1);
                        check(sync_delta == e.value[7:0], e.req, 32'(sync_delta), e.value);
                    end else begin
                        check(res_valid && !sync_req, e.req, {31'd0, res_valid}, 1);
                        check(res_sp == e.value, e.req, res_sp, e.value);
                    end
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", expq.size(), 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(res_valid == 0 && sync_req == 0, "R1 outputs low in reset",
              {30'd0, sync_req, res_valid}, 0);
        @(posedge clk); #2;
        rst = 0;
        do_op(2'b01, 1, "R1 first pop reports reset pointer", 0);
        // R2: 4-byte pushes and calls
        for (int i = 0; i < 4; i++) do_op(i[0] ? 2'b10 : 2'b00, 1, "R2 push/call 4B", 0);
        // R3: 2-byte pops and returns
        for (int i = 0; i < 3; i++) do_op(i[0] ? 2'b11 : 2'b01, 0, "R3 pop/ret 2B", 0);
        // R3: push then pop of same size
        do_op(2'b00, 0, "R3 push 2B", 0);
        do_op(2'b01, 0, "R3 pop after push", 0);
        do_op(2'b10, 1, "R2 call mixed", 0);
        do_op(2'b11, 1, "R3 ret mixed", 0);
        idle(2);
        // R5: touch folds, second touch zero
        do_op(2'b00, 1, "R2 push before touch", 0);
        do_touch(0);
        do_touch(0);
        do_op(2'b01, 0, "R5 pop after fold", 0);
        // R7: write loads base without sync
        do_write(32'h0001_0000, 0);
        do_op(2'b01, 1, "R7 pop after write", 0);
        idle(2);
        // R6: push burst to -128 limit, 33rd stalls
        do_write(32'h0002_0000, 0);
        for (int i = 0; i < 32; i++) do_op(2'b00, 1, "R6 push to lower limit", 0);
        do_op(2'b00, 1, "R6 push past lower limit", 1);
        // R6: pop burst to 126, 64th stalls
        do_touch(0);
        for (int i = 0; i < 63; i++) do_op(2'b01, 0, "R6 pop to upper limit", 0);
        do_op(2'b01, 0, "R6 pop past upper limit", 1);
        // R10: in-range burst without sync (checked by monitor)
        for (int i = 0; i < 8; i++) do_op(2'b00, 0, "R10 in-range no sync", 0);
        // R9: touch and write with a competing op
        do_touch(1);
        do_op(2'b01, 1, "R9 op retried after touch", 0);
        do_write(32'h0003_0000, 1);
        do_op(2'b01, 1, "R9 op retried after write", 0);
        // R8: commit, move, flush
        do_op(2'b00, 1, "R8 push before commit", 0);
        do_commit();
        do_op(2'b00, 1, "R8 push after commit", 0);
        do_touch(0);
        do_write(32'h0004_0000, 0);
        do_flush(0);
        do_op(2'b01, 1, "R8 pop after flush", 0);
        do_flush(1);
        do_op(2'b01, 1, "R8 flush wins over all", 0);
        idle(4);
        check(expq.size() == 0, "R4 all results seen", 32'(expq.size()), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule